// File: doc/BRIEF.md
# Receiver polling cycle sequencer

This block runs the duty-cycled listening loop of a low-power radio receiver. While polling is enabled it steps repeatedly through four phases: a programmable sleep, a PLL start-up that waits for lock, a fixed-length start-up of the signal-processing path, and a bit-check window in which the receiver is sensitive to an incoming transmission. The PLL, the demodulator and the bit-check decision are outside the block. They appear only as a lock input and as a done/pass handshake.

The sleep length is the 5-bit sleep field times a base unit of `BASE_CYC` clock cycles, times 1 or `XFACT` depending on the extension bit. A failed bit check sends the loop back to sleep, and the timer is reloaded from the field and extension values present at that moment. A passed check raises a one-cycle wake pulse and holds the receive path powered until polling is disabled. If the PLL does not lock within `LOCK_TMO` cycles, the loop goes back to sleep and a sticky error flag is raised. Dropping the polling enable parks the sequencer in idle with every phase enable low.

Top module: `rx_poll_seq`

## Requirements
- R1: With `sleep_ext`=0 and a nonzero `sleep_field` F, the sleep phase lasts exactly F×`BASE_CYC` cycles. During that phase `pll_on`, `sig_on`, `chk_on` and `rx_sens` are all 0.
- R2: With `sleep_ext`=1 the sleep phase lasts F×`BASE_CYC`×`XFACT` cycles.
- R3: A `sleep_field` of 0 skips the sleep phase, and PLL start-up begins on the cycle after the loop is entered.
- R4: During PLL start-up only `pll_on` is 1. The phase ends one cycle after `pll_lock` is seen high, and then the signal start-up begins. This still holds when lock arrives in the last cycle of the timeout.
- R5: Signal start-up lasts exactly `SIGPROC_CYC` cycles, with `pll_on` and `sig_on` at 1 and `chk_on` and `rx_sens` at 0.
- R6: In the bit-check window `pll_on`, `sig_on`, `chk_on` and `rx_sens` are all 1. The window ends in the cycle after `chk_done` is seen high.
- R7: A check with `chk_done`=1 and `chk_ok`=1 produces `wake` high for exactly one cycle, on the first receive cycle. In the receive state `pll_on`, `sig_on` and `rx_sens` stay 1 and `chk_on` is 0, until `poll_en` drops.
- R8: A check with `chk_done`=1 and `chk_ok`=0 returns to sleep. That sleep length is computed from the `sleep_field` and `sleep_ext` values at the moment of return, not from the values used by the earlier sleep.
- R9: If the PLL start-up lasts `LOCK_TMO` cycles without lock, the sequencer returns to sleep. `lock_err` becomes 1 from the first cycle of that sleep and stays 1 until reset, including across polling disable.
- R10: After reset, and one cycle after `poll_en` is 0, `pll_on`, `sig_on`, `chk_on`, `rx_sens` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_en | input | 1 | Polling enable; 0 parks the sequencer in idle |
| sleep_field | input | SLEEP_W | Sleep length in base units |
| sleep_ext | input | 1 | 0: factor 1, 1: factor XFACT |
| pll_lock | input | 1 | PLL lock indication |
| chk_done | input | 1 | Bit-check decision available |
| chk_ok | input | 1 | Bit-check result, valid with chk_done |
| pll_on | output | 1 | PLL enable |
| sig_on | output | 1 | Signal-processing path enable |
| chk_on | output | 1 | Bit-check window active |
| rx_sens | output | 1 | Receiver is sensitive to a transmitter |
| wake | output | 1 | One-cycle pulse on entry to full receive |
| lock_err | output | 1 | Sticky PLL lock timeout flag |

## Verification
The hardest situations to reach are the lock timeout that races a lock arriving in the final allowed cycle, and the failed-check return to sleep with a sleep field changed in mid-loop. The bench drives the lock input and the bit-check handshake from small behavioural models of the PLL and the decision logic, each keyed to how many cycles its enable has been high. The first PLL attempt can be made to never lock, and lock can be placed exactly on the timeout boundary. The first check can be made to fail, and the sleep field is rewritten while the first sleep is still running. Every phase is then checked as an output segment of exact length against a queue of expected segments.

// File: rtl/rx_poll_pkg.sv
// Package: shared state encoding for the receiver polling sequencer.
package rx_poll_pkg;
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_SLEEP,
        PS_PLL,
        PS_SIG,
        PS_CHECK,
        PS_RECV
    } poll_state_t;
endpackage

// File: rtl/rx_sleep_timer.sv
// Sleep timer: when loaded, captures field x BASE_CYC x (1 or XFACT) and
// counts down while run is high. expired is high when the count is zero.
// Assumes the loader never loads a zero field (the sequencer skips sleep then).
module rx_sleep_timer #(
    parameter int SLEEP_W  = 5,
    parameter int BASE_CYC = 1024,
    parameter int XFACT    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               run,
    input  logic [SLEEP_W-1:0] field,
    input  logic               ext,
    output logic               expired
);
    localparam int CNT_W = SLEEP_W + $clog2(BASE_CYC * XFACT);
    localparam int UNIT1 = BASE_CYC;
    localparam int UNIT8 = BASE_CYC * XFACT;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    // Purpose: total sleep length in cycles for the current settings.
    always_comb begin
        span = CNT_W'(field) * (ext ? CNT_W'(UNIT8) : CNT_W'(UNIT1));
    end

    // Purpose: load the span minus one, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= span - CNT_W'(1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rx_phase_timer.sv
// Phase timer: a load sets up a window of CYC cycles. expired is high in the
// last cycle of the window while run is held. Assumes CYC >= 1.
module rx_phase_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int W = (CYC < 2) ? 1 : $clog2(CYC);

    logic [W-1:0] cnt;

    // Purpose: load CYC-1, then count down while the phase runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(CYC - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rx_poll_seq.sv
// Receiver polling sequencer: cycles sleep -> PLL start-up -> signal start-up
// -> bit check while poll_en is high. A pass enters receive with a one-cycle
// wake pulse. A fail or a lock timeout re-enters sleep, reloaded from the
// current settings. Assumes pll_lock, chk_done and chk_ok are synchronous to clk.
module rx_poll_seq #(
    parameter int SLEEP_W     = 5,
    parameter int BASE_CYC    = 1024,
    parameter int XFACT       = 8,
    parameter int SIGPROC_CYC = 64,
    parameter int LOCK_TMO    = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll_en,
    input  logic [SLEEP_W-1:0] sleep_field,
    input  logic               sleep_ext,
    input  logic               pll_lock,
    input  logic               chk_done,
    input  logic               chk_ok,
    output logic               pll_on,
    output logic               sig_on,
    output logic               chk_on,
    output logic               rx_sens,
    output logic               wake,
    output logic               lock_err
);
    import rx_poll_pkg::*;

    poll_state_t st, nxt;
    logic ld_slp, ld_tmo, ld_sig, rearm, set_err, wake_d;
    logic slp_exp, tmo_exp, sig_exp;
    logic slp_zero;

    assign slp_zero = (sleep_field == '0);

    rx_sleep_timer #(.SLEEP_W(SLEEP_W), .BASE_CYC(BASE_CYC), .XFACT(XFACT)) u_slp (
        .clk(clk), .rst_n(rst_n), .load(ld_slp), .run(st == PS_SLEEP),
        .field(sleep_field), .ext(sleep_ext), .expired(slp_exp)
    );

    rx_phase_timer #(.CYC(LOCK_TMO)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load(ld_tmo), .run(st == PS_PLL), .expired(tmo_exp)
    );

    rx_phase_timer #(.CYC(SIGPROC_CYC)) u_sig (
        .clk(clk), .rst_n(rst_n), .load(ld_sig), .run(st == PS_SIG), .expired(sig_exp)
    );

    // Purpose: next phase, timer loads and event strobes.
    always_comb begin
        nxt     = st;
        ld_slp  = 1'b0;
        ld_tmo  = 1'b0;
        ld_sig  = 1'b0;
        rearm   = 1'b0;
        set_err = 1'b0;
        wake_d  = 1'b0;
        case (st)
            PS_IDLE:  rearm = 1'b1;
            PS_SLEEP: if (slp_exp) begin
                nxt    = PS_PLL;
                ld_tmo = 1'b1;
            end
            PS_PLL: if (pll_lock) begin
                nxt    = PS_SIG;
                ld_sig = 1'b1;
            end else if (tmo_exp) begin
                rearm   = 1'b1;
                set_err = 1'b1;
            end
            PS_SIG: if (sig_exp) nxt = PS_CHECK;
            PS_CHECK: if (chk_done) begin
                if (chk_ok) begin
                    nxt    = PS_RECV;
                    wake_d = 1'b1;
                end else begin
                    rearm = 1'b1;
                end
            end
            PS_RECV: nxt = PS_RECV;
            default: nxt = PS_IDLE;
        endcase
        if (rearm) begin
            nxt    = slp_zero ? PS_PLL : PS_SLEEP;
            ld_slp = !slp_zero;
            ld_tmo = slp_zero;
        end
        if (!poll_en) begin
            nxt     = PS_IDLE;
            ld_slp  = 1'b0;
            ld_tmo  = 1'b0;
            ld_sig  = 1'b0;
            set_err = 1'b0;
            wake_d  = 1'b0;
        end
    end

    // Purpose: phase register, wake pulse and sticky lock error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_IDLE;
            wake     <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            st       <= nxt;
            wake     <= wake_d;
            lock_err <= lock_err | set_err;
        end
    end

    // Purpose: decode the phase enables from the current phase.
    always_comb begin
        pll_on  = (st == PS_PLL) || (st == PS_SIG) || (st == PS_CHECK) || (st == PS_RECV);
        sig_on  = (st == PS_SIG) || (st == PS_CHECK) || (st == PS_RECV);
        chk_on  = (st == PS_CHECK);
        rx_sens = (st == PS_CHECK) || (st == PS_RECV);
    end
endmodule

// File: rtl/rx_poll_seq_chk.sv
// Checker: temporal properties on the ports of rx_poll_seq, bound to it below.
module rx_poll_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic poll_en,
    input logic pll_lock,
    input logic pll_on,
    input logic sig_on,
    input logic chk_on,
    input logic rx_sens,
    input logic wake,
    input logic lock_err
);
    p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    p_wake_after_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(chk_on));

    p_sig_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_on) |-> $past(pll_lock));

    p_check_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_on |-> (pll_on && sig_on && rx_sens));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_en |=> (!pll_on && !sig_on && !chk_on && !rx_sens && !wake));
endmodule

bind rx_poll_seq rx_poll_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .pll_lock(pll_lock),
    .pll_on(pll_on), .sig_on(sig_on), .chk_on(chk_on), .rx_sens(rx_sens),
    .wake(wake), .lock_err(lock_err)
);

// File: tb/sim_rx_poll_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected output segments (value and
// length); the monitor closes each run of constant outputs and compares it.
module sim_rx_poll_seq;
    localparam int BASE = 4;
    localparam int XF   = 8;
    localparam int SIGC = 5;
    localparam int TMO  = 10;

    // segment bit order {le, wake, sens, chk, sig, pll}
    localparam logic [5:0] V_SLP = 6'b000000;
    localparam logic [5:0] V_PLL = 6'b000001;
    localparam logic [5:0] V_SIG = 6'b000011;
    localparam logic [5:0] V_CHK = 6'b001111;
    localparam logic [5:0] V_WK  = 6'b011011;
    localparam logic [5:0] V_RCV = 6'b001011;
    localparam logic [5:0] V_LE  = 6'b100000;

    typedef struct {
        string      tag;
        logic [6:0] v;
        int         len;
    } seg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [4:0] fld = '0;
    logic ext = 1'b0;
    logic lock = 1'b0;
    logic cdone = 1'b0;
    logic cok = 1'b0;
    logic pll_on, sig_on, chk_on, rx_sens, wake, lock_err;

    int total = 0;
    int bad = 0;
    int tot = 0;
    int lk_k = 1, lk_bad_n = 0, ck_m = 1, ck_bad_n = 0;
    int lk_cnt = 0, ck_cnt = 0, run = 0;
    logic pll_prev = 1'b0, att_bad = 1'b0;
    logic [6:0] prev_v = '0;
    seg_t exp_q[$];

    always #2 clk = ~clk;

    rx_poll_seq #(.SLEEP_W(5), .BASE_CYC(BASE), .XFACT(XF), .SIGPROC_CYC(SIGC), .LOCK_TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .poll_en(en), .sleep_field(fld), .sleep_ext(ext),
        .pll_lock(lock), .chk_done(cdone), .chk_ok(cok),
        .pll_on(pll_on), .sig_on(sig_on), .chk_on(chk_on), .rx_sens(rx_sens),
        .wake(wake), .lock_err(lock_err)
    );

    task automatic push(input string tag, input logic [5:0] v, input int n);
        seg_t s;
        s.tag = tag;
        s.v = {1'b1, v};
        s.len = n;
        exp_q.push_back(s);
        tot += n;
    endtask

    task automatic go();
        en = 1'b1;
        repeat (tot) @(negedge clk);
        en = 1'b0;
        tot = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic close_run(input logic [6:0] v, input int n);
        seg_t s;
        if (v[6]) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected segment vec=%b len=%0d expected none", v, n);
            end else begin
                s = exp_q.pop_front();
                if (s.v !== v || s.len != n) begin
                    bad++;
                    $display("FAIL %s segment vec=%b len=%0d expected vec=%b len=%0d",
                             s.tag, v, n, s.v, s.len);
                end
            end
        end
    endtask

    // Models of the PLL and bit-check decision, plus the output monitor.
    initial forever begin
        @(posedge clk);
        #1;
        if (pll_on) begin
            if (!pll_prev) begin
                att_bad = (lk_bad_n > 0);
                if (att_bad) lk_bad_n--;
                lk_cnt = 0;
            end
            lk_cnt++;
        end else begin
            lk_cnt = 0;
        end
        pll_prev = pll_on;
        lock = pll_on && !att_bad && (lk_cnt >= lk_k);
        if (chk_on) ck_cnt++; else ck_cnt = 0;
        if (chk_on && ck_cnt == ck_m) begin
            cdone = 1'b1;
            cok = !(ck_bad_n > 0);
            if (ck_bad_n > 0) ck_bad_n--;
        end else begin
            cdone = 1'b0;
            cok = 1'b0;
        end
        begin
            logic [6:0] v;
            v = {en, lock_err, wake, rx_sens, chk_on, sig_on, pll_on};
            if (run == 0 || v == prev_v) begin
                run++;
            end else begin
                close_run(prev_v, run);
                run = 1;
            end
            prev_v = v;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if ({pll_on, sig_on, chk_on, rx_sens, wake, lock_err} !== 6'b0) begin
            bad++;
            $display("FAIL R10 reset outputs=%b expected=000000",
                     {pll_on, sig_on, chk_on, rx_sens, wake, lock_err});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R4 R5 R6 R7: basic pass, factor 1
        fld = 5'd3; ext = 1'b0; lk_k = 2; ck_m = 3;
        push("R1", V_SLP, 3 * BASE);
        push("R4", V_PLL, 2);
        push("R5", V_SIG, SIGC);
        push("R6", V_CHK, 3);
        push("R7", V_WK, 1);
        push("R7", V_RCV, 3);
        go();

        // R2: extended sleep
        fld = 5'd2; ext = 1'b1; lk_k = 1; ck_m = 1;
        push("R2", V_SLP, 2 * BASE * XF);
        push("R4", V_PLL, 1);
        push("R5", V_SIG, SIGC);
        push("R6", V_CHK, 1);
        push("R7", V_WK, 1);
        push("R7", V_RCV, 2);
        go();

        // R3: zero field skips sleep
        fld = 5'd0; ext = 1'b0; lk_k = 2; ck_m = 2;
        push("R3", V_PLL, 2);
        push("R5", V_SIG, SIGC);
        push("R6", V_CHK, 2);
        push("R7", V_WK, 1);
        push("R7", V_RCV, 2);
        go();

        // R8: failed check re-enters sleep with the field written mid-sleep
        fld = 5'd1; ext = 1'b0; lk_k = 1; ck_m = 1; ck_bad_n = 1;
        push("R8", V_SLP, BASE);
        push("R4", V_PLL, 1);
        push("R5", V_SIG, SIGC);
        push("R6", V_CHK, 1);
        push("R8", V_SLP, 2 * BASE);
        push("R4", V_PLL, 1);
        push("R5", V_SIG, SIGC);
        push("R6", V_CHK, 1);
        push("R7", V_WK, 1);
        push("R7", V_RCV, 2);
        en = 1'b1;
        repeat (2) @(negedge clk);
        fld = 5'd2;
        repeat (tot - 2) @(negedge clk);
        en = 1'b0;
        tot = 0;
        repeat (3) @(negedge clk);

        // R4: lock in the last cycle of the timeout wins, no error
        fld = 5'd1; ext = 1'b0; lk_k = TMO; ck_m = 1;
        push("R1", V_SLP, BASE);
        push("R4", V_PLL, TMO);
        push("R5", V_SIG, SIGC);
        push("R6", V_CHK, 1);
        push("R7", V_WK, 1);
        push("R7", V_RCV, 2);
        go();

        // R9: lock timeout, sticky error
        fld = 5'd1; ext = 1'b0; lk_k = 3; lk_bad_n = 1; ck_m = 2;
        push("R1", V_SLP, BASE);
        push("R9", V_PLL, TMO);
        push("R9", V_LE | V_SLP, BASE);
        push("R4", V_LE | V_PLL, 3);
        push("R5", V_LE | V_SIG, SIGC);
        push("R6", V_LE | V_CHK, 2);
        push("R7", V_LE | V_WK, 1);
        push("R7", V_LE | V_RCV, 2);
        go();

        // R10: disable in the middle of a long sleep
        fld = 5'd5; ext = 1'b1; lk_k = 1; ck_m = 1;
        push("R10", V_LE | V_SLP, 20);
        go();
        total++;
        if ({pll_on, sig_on, chk_on, rx_sens, wake, lock_err} !== 6'b000001) begin
            bad++;
            $display("FAIL R10 idle outputs=%b expected=000001",
                     {pll_on, sig_on, chk_on, rx_sens, wake, lock_err});
        end

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R6 segments left actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule